// File: doc/BRIEF.md
# Caption Row Scroll Controller

This block keeps track of where text lands on a row-based caption display and how the visible rows move. It holds the write position (row and column), the index of the row shown at the top of the active window, and a smooth-scroll offset counted in scan lines. It also asks the character store to blank rows as they are opened or when the whole display is wiped. Character storage, the font and pixel generation sit in neighbouring blocks that consume these outputs.

Two display styles are supported. In text style, a box of up to 15 rows fills from its top row downward. Once the box is full, it scrolls. In roll-up style, a window of 2, 3 or 4 rows is anchored on a base row. Every new line rolls the window up by one row. A scroll is not shown all at once: the window index moves immediately, and the offset then counts down one scan line per frame tick until a full 13-line row height has been covered. Rows form a ring inside the window, so a scroll only retargets indices and never moves stored characters.

Commands arrive as a 3-bit code with a strobe. Character writes, carriage returns and frame ticks are separate single-cycle strobes. Every stimulus takes effect at the second rising clock edge after it is sampled.

Top module: `caption_scroll_ctrl`

## Requirements
- R1: After reset, wrRow = 1, wrCol = 1, topRow = 1, scrollOfs = 0, and clrReq and clrAll are low; the text window is rows 1 to 15, and processing stays paused until a start or resume command arrives.
- R2: Each character write moves wrCol up by one. Once wrCol is 32 it stays at 32, so further writes overwrite the last column and never wrap.
- R3: In text style, a carriage return while the window still has unused rows moves wrRow to the next row and sets wrCol to 1. It leaves topRow unchanged and pulses clrReq for one cycle with clrRow equal to the newly opened row.
- R4: A carriage return when every window row is in use starts a scroll. topRow advances by one (wrapping from the window bottom to the window top), and wrRow moves to the row that was on top. clrReq pulses for that row, and scrollOfs becomes 13.
- R5: Each frame tick lowers a non-zero scrollOfs by one. At 0, scrollOfs stays at 0.
- R6: A carriage return while scrollOfs is non-zero sets scrollOfs to 0 at once, which finishes the pending scroll, and still opens the next row.
- R7: Command code 0 (start text) pulses clrAll for one cycle and latches the text window from cfgTextBase (bottom row) and cfgTextRows (row count). It then puts the pointer and topRow on the window's top row, column 1, with scrollOfs 0. A base of 0 or above 15 is taken as 15, a count of 0 as 1, and a count above the base as the base.
- R8: Command code 5 (pause) makes later character writes and carriage returns have no effect. Command code 1 (resume text) re-enables them and continues from the saved pointer. If roll-up style was active, it instead re-latches the text window and starts at its top row, column 1. Resume never pulses clrAll.
- R9: Command codes 2, 3 and 4 select roll-up style with a window depth equal to the code. The window's bottom is the base row, and the pointer goes to the bottom row, column 1, with topRow at the window top and scrollOfs 0. In this style every carriage return scrolls as in R4.
- R10: Command code 6 stores cmdRow as the roll-up base row. A base below the depth is raised to the depth. In roll-up style it re-anchors the window as in R9. In text style it leaves the pointer and topRow unchanged.
- R11: Command code 7 is ignored: the display style, pause state, pointer and topRow are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe |
| cmdCode | input | 3 | Command code (see R7 to R11) |
| cmdRow | input | 4 | Row operand for the set-base command |
| evWrite | input | 1 | Character write strobe |
| evCr | input | 1 | Carriage return strobe |
| frameTick | input | 1 | One pulse per displayed frame |
| cfgTextRows | input | 4 | Text window row count |
| cfgTextBase | input | 4 | Text window bottom row |
| wrRow | output | 4 | Row that receives the next character |
| wrCol | output | 6 | Column that receives the next character (1 to 32) |
| topRow | output | 4 | Row index shown at the top of the window |
| scrollOfs | output | 4 | Scan lines of scroll still to be shown |
| clrReq | output | 1 | One-cycle request to blank row clrRow |
| clrRow | output | 4 | Row to blank |
| clrAll | output | 1 | One-cycle request to blank the whole display |

## Verification
The hardest situation to reach is a carriage return that lands in the middle of a smooth scroll while the ring index is about to wrap. Only a full window can put the block there, so the stimulus first latches a small text window (rows 3 to 5), fills it, and triggers a scroll. It then counts frame ticks down partway before issuing the next return. Roll-up re-anchoring is reached by first setting a base row in text style, where it must change nothing, and then switching depth and base while the roll-up window is live.

// File: rtl/caption_scroll_pkg.sv
package caption_scroll_pkg;

  typedef enum logic [2:0] {
    CMD_START  = 3'd0,
    CMD_RESUME = 3'd1,
    CMD_ROLL2  = 3'd2,
    CMD_ROLL3  = 3'd3,
    CMD_ROLL4  = 3'd4,
    CMD_PAUSE  = 3'd5,
    CMD_BASE   = 3'd6,
    CMD_NONE   = 3'd7
  } cmd_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic anchorTop;
    logic anchorBottom;
    logic clearAll;
    logic advCol;
    logic newLine;
    logic tick;
  } dp_strobe_t;

endpackage

// File: rtl/scroll_ctrl.sv
module scroll_ctrl
  import caption_scroll_pkg::*;
#(
  parameter int ROWS_MAX = 15,
  parameter int ROW_W    = $clog2(ROWS_MAX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [2:0]       cmdCode,
  input  logic [ROW_W-1:0] cmdRow,
  input  logic             evWrite,
  input  logic             evCr,
  input  logic             frameTick,
  input  logic [ROW_W-1:0] cfgTextRows,
  input  logic [ROW_W-1:0] cfgTextBase,
  output dp_strobe_t       stb,
  output logic [ROW_W-1:0] winLo,
  output logic [ROW_W-1:0] winHi,
  output logic [ROW_W-1:0] winN
);

  localparam logic [ROW_W-1:0] MAXR = ROW_W'(ROWS_MAX);
  localparam logic [ROW_W-1:0] ONE  = ROW_W'(1);

  logic             modeRoll;
  logic             active;
  logic [ROW_W-1:0] rollDepth;
  logic [ROW_W-1:0] rollBase;
  logic [ROW_W-1:0] textBase, textN;

  // clamp the text window so it stays inside rows 1..ROWS_MAX
  always_comb begin
    textBase = (cfgTextBase == '0 || cfgTextBase > MAXR) ? MAXR : cfgTextBase;
    if (cfgTextRows == '0)          textN = ONE;
    else if (cfgTextRows > textBase) textN = textBase;
    else                             textN = cfgTextRows;
  end

  function automatic logic [ROW_W-1:0] rollHi(input logic [ROW_W-1:0] b,
                                               input logic [ROW_W-1:0] d);
    if (b < d)         return d;
    else if (b > MAXR) return MAXR;
    else               return b;
  endfunction

  logic [ROW_W-1:0] cmdDepth, hiNew, hiBase;
  assign cmdDepth = ROW_W'(cmdCode);
  assign hiNew    = rollHi(rollBase, cmdDepth);
  assign hiBase   = rollHi(cmdRow, rollDepth);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeRoll  <= 1'b0;
      active    <= 1'b0;
      rollDepth <= ROW_W'(2);
      rollBase  <= MAXR;
      winLo     <= ONE;
      winHi     <= MAXR;
      winN      <= MAXR;
      stb       <= '0;
    end else begin
      stb        <= '0;
      stb.tick   <= frameTick;
      stb.advCol <= evWrite && active;
      stb.newLine <= evCr && active;
      if (cmdValid) begin
        case (cmdCode)
          CMD_START: begin
            modeRoll      <= 1'b0;
            active        <= 1'b1;
            winHi         <= textBase;
            winN          <= textN;
            winLo         <= textBase - textN + ONE;
            stb.anchorTop <= 1'b1;
            stb.clearAll  <= 1'b1;
          end
          CMD_RESUME: begin
            active   <= 1'b1;
            modeRoll <= 1'b0;
            if (modeRoll) begin
              winHi         <= textBase;
              winN          <= textN;
              winLo         <= textBase - textN + ONE;
              stb.anchorTop <= 1'b1;
            end
          end
          CMD_ROLL2, CMD_ROLL3, CMD_ROLL4: begin
            modeRoll         <= 1'b1;
            active           <= 1'b1;
            rollDepth        <= cmdDepth;
            winHi            <= hiNew;
            winN             <= cmdDepth;
            winLo            <= hiNew - cmdDepth + ONE;
            stb.anchorBottom <= 1'b1;
          end
          CMD_PAUSE: active <= 1'b0;
          CMD_BASE: begin
            rollBase <= cmdRow;
            if (modeRoll) begin
              winHi            <= hiBase;
              winN             <= rollDepth;
              winLo            <= hiBase - rollDepth + ONE;
              stb.anchorBottom <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R11
  rsvd_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == CMD_NONE) |=> ($stable(modeRoll) && $stable(active)));

  // R8
  pause_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == CMD_PAUSE) |=> ##1 (!stb.advCol && !stb.newLine || active));

endmodule

// File: rtl/scroll_datapath.sv
module scroll_datapath
  import caption_scroll_pkg::*;
#(
  parameter int ROWS_MAX  = 15,
  parameter int COLS      = 32,
  parameter int ROW_LINES = 13,
  parameter int ROW_W     = $clog2(ROWS_MAX + 1),
  parameter int COL_W     = $clog2(COLS + 1),
  parameter int OFS_W     = $clog2(ROW_LINES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dp_strobe_t       stb,
  input  logic [ROW_W-1:0] winLo,
  input  logic [ROW_W-1:0] winHi,
  input  logic [ROW_W-1:0] winN,
  output logic [ROW_W-1:0] wrRow,
  output logic [COL_W-1:0] wrCol,
  output logic [ROW_W-1:0] topRow,
  output logic [OFS_W-1:0] scrollOfs,
  output logic             clrReq,
  output logic [ROW_W-1:0] clrRow,
  output logic             clrAll
);

  localparam logic [COL_W-1:0] LASTCOL = COL_W'(COLS);
  localparam logic [OFS_W-1:0] FULLOFS = OFS_W'(ROW_LINES);

  logic [ROW_W-1:0] fillCnt;
  logic [ROW_W-1:0] nxtWr, nxtTop;
  logic             winFull, midScroll, anchoring;

  // rows form a ring inside winLo..winHi
  assign nxtWr     = (wrRow == winHi)  ? winLo : wrRow + ROW_W'(1);
  assign nxtTop    = (topRow == winHi) ? winLo : topRow + ROW_W'(1);
  assign winFull   = (fillCnt >= winN);
  assign midScroll = (scrollOfs != '0);
  assign anchoring = stb.anchorTop || stb.anchorBottom;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrRow     <= ROW_W'(1);
      wrCol     <= COL_W'(1);
      topRow    <= ROW_W'(1);
      fillCnt   <= ROW_W'(1);
      scrollOfs <= '0;
      clrReq    <= 1'b0;
      clrRow    <= ROW_W'(1);
      clrAll    <= 1'b0;
    end else begin
      clrReq <= 1'b0;
      clrAll <= stb.clearAll;
      if (stb.anchorTop) begin
        wrRow     <= winLo;
        topRow    <= winLo;
        fillCnt   <= ROW_W'(1);
        wrCol     <= COL_W'(1);
        scrollOfs <= '0;
      end else if (stb.anchorBottom) begin
        wrRow     <= winHi;
        topRow    <= winLo;
        fillCnt   <= winN;
        wrCol     <= COL_W'(1);
        scrollOfs <= '0;
      end else if (stb.newLine) begin
        wrCol  <= COL_W'(1);
        wrRow  <= nxtWr;
        clrReq <= 1'b1;
        clrRow <= nxtWr;
        if (winFull) begin
          topRow    <= nxtTop;
          scrollOfs <= midScroll ? '0 : FULLOFS;
        end else begin
          fillCnt   <= fillCnt + ROW_W'(1);
          scrollOfs <= '0;
        end
      end else begin
        if (stb.advCol && wrCol < LASTCOL) wrCol <= wrCol + COL_W'(1);
        if (stb.tick && midScroll) scrollOfs <= scrollOfs - OFS_W'(1);
      end
    end
  end

  // R2
  col_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrCol >= COL_W'(1)) && (wrCol <= LASTCOL));

  // R5
  ofs_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.tick && !stb.newLine && !anchoring && midScroll)
      |=> (scrollOfs == $past(scrollOfs) - OFS_W'(1)));

  // R6
  cr_jump_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.newLine && !anchoring && midScroll) |=> (scrollOfs == '0));

  // R3
  row_in_win_chk: assert property (@(posedge clk) disable iff (!rstN)
    !anchoring |-> (wrRow >= winLo && wrRow <= winHi &&
                    topRow >= winLo && topRow <= winHi));

endmodule

// File: rtl/caption_scroll_ctrl.sv
module caption_scroll_ctrl
  import caption_scroll_pkg::*;
#(
  parameter int ROWS_MAX  = 15,
  parameter int COLS      = 32,
  parameter int ROW_LINES = 13,
  parameter int ROW_W     = $clog2(ROWS_MAX + 1),
  parameter int COL_W     = $clog2(COLS + 1),
  parameter int OFS_W     = $clog2(ROW_LINES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [2:0]       cmdCode,
  input  logic [ROW_W-1:0] cmdRow,
  input  logic             evWrite,
  input  logic             evCr,
  input  logic             frameTick,
  input  logic [ROW_W-1:0] cfgTextRows,
  input  logic [ROW_W-1:0] cfgTextBase,
  output logic [ROW_W-1:0] wrRow,
  output logic [COL_W-1:0] wrCol,
  output logic [ROW_W-1:0] topRow,
  output logic [OFS_W-1:0] scrollOfs,
  output logic             clrReq,
  output logic [ROW_W-1:0] clrRow,
  output logic             clrAll
);

  dp_strobe_t       stb;
  logic [ROW_W-1:0] winLo, winHi, winN;

  scroll_ctrl #(.ROWS_MAX(ROWS_MAX), .ROW_W(ROW_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdRow(cmdRow), .evWrite(evWrite), .evCr(evCr), .frameTick(frameTick),
    .cfgTextRows(cfgTextRows), .cfgTextBase(cfgTextBase), .stb(stb),
    .winLo(winLo), .winHi(winHi), .winN(winN)
  );

  scroll_datapath #(.ROWS_MAX(ROWS_MAX), .COLS(COLS), .ROW_LINES(ROW_LINES),
                    .ROW_W(ROW_W), .COL_W(COL_W), .OFS_W(OFS_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .winLo(winLo), .winHi(winHi),
    .winN(winN), .wrRow(wrRow), .wrCol(wrCol), .topRow(topRow),
    .scrollOfs(scrollOfs), .clrReq(clrReq), .clrRow(clrRow), .clrAll(clrAll)
  );

endmodule

// File: tb/sim_caption_scroll_ctrl.sv
`timescale 1ns/1ps
module sim_caption_scroll_ctrl;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [2:0] cmdCode = 3'd0;
  logic [3:0] cmdRow = 4'd0;
  logic       evWrite = 1'b0, evCr = 1'b0, frameTick = 1'b0;
  logic [3:0] cfgTextRows = 4'd15, cfgTextBase = 4'd15;
  logic [3:0] wrRow, topRow, scrollOfs, clrRow;
  logic [5:0] wrCol;
  logic       clrReq, clrAll;

  int nChecks = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  caption_scroll_ctrl u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdRow(cmdRow), .evWrite(evWrite), .evCr(evCr), .frameTick(frameTick),
    .cfgTextRows(cfgTextRows), .cfgTextBase(cfgTextBase), .wrRow(wrRow),
    .wrCol(wrCol), .topRow(topRow), .scrollOfs(scrollOfs), .clrReq(clrReq),
    .clrRow(clrRow), .clrAll(clrAll)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chkPos(input string req, input int r, input int c, input int t, input int o);
    chk(req, "wrRow", int'(wrRow), r);
    chk(req, "wrCol", int'(wrCol), c);
    chk(req, "topRow", int'(topRow), t);
    chk(req, "scrollOfs", int'(scrollOfs), o);
  endtask

  // drive at a falling edge, release one cycle later, return at the sample point
  task automatic apply(input logic w, input logic cr, input logic tk,
                       input logic cv, input logic [2:0] code, input logic [3:0] row);
    evWrite = w; evCr = cr; frameTick = tk; cmdValid = cv; cmdCode = code; cmdRow = row;
    @(negedge clk);
    evWrite = 1'b0; evCr = 1'b0; frameTick = 1'b0; cmdValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic doWrite(); apply(1, 0, 0, 0, 3'd0, 4'd0); endtask
  task automatic doCr();    apply(0, 1, 0, 0, 3'd0, 4'd0); endtask
  task automatic doTick();  apply(0, 0, 1, 0, 3'd0, 4'd0); endtask
  task automatic doCmd(input logic [2:0] code, input logic [3:0] row);
    apply(0, 0, 0, 1, code, row);
  endtask

  task automatic testReset();
    chkPos("R1", 1, 1, 1, 0);
    chk("R1", "clrReq", int'(clrReq), 0);
    chk("R1", "clrAll", int'(clrAll), 0);
    doWrite();
    chk("R1", "paused write wrCol", int'(wrCol), 1);
  endtask

  task automatic testTextFillScroll();
    cfgTextRows = 4'd3; cfgTextBase = 4'd5;
    doCmd(3'd0, 4'd0);
    chk("R7", "clrAll", int'(clrAll), 1);
    chkPos("R7", 3, 1, 3, 0);
    repeat (3) doWrite();
    chk("R2", "wrCol", int'(wrCol), 4);
    doCr();
    chkPos("R3", 4, 1, 3, 0);
    chk("R3", "clrReq", int'(clrReq), 1);
    chk("R3", "clrRow", int'(clrRow), 4);
    doCr();
    chkPos("R3", 5, 1, 3, 0);
    doCr();
    chkPos("R4", 3, 1, 4, 13);
    chk("R4", "clrRow", int'(clrRow), 3);
    chk("R4", "clrReq", int'(clrReq), 1);
    doTick();
    chk("R5", "scrollOfs", int'(scrollOfs), 12);
    repeat (11) doTick();
    chk("R5", "scrollOfs", int'(scrollOfs), 1);
    doTick();
    chk("R5", "scrollOfs", int'(scrollOfs), 0);
    doTick();
    chk("R5", "scrollOfs held", int'(scrollOfs), 0);
    doCr();
    chkPos("R4", 4, 1, 5, 13);
    doTick();
    doCr();
    chkPos("R6", 5, 1, 3, 0);
  endtask

  task automatic testColumnLimit();
    repeat (31) doWrite();
    chk("R2", "wrCol at end", int'(wrCol), 32);
    repeat (9) doWrite();
    chk("R2", "wrCol saturated", int'(wrCol), 32);
  endtask

  task automatic testPauseResume();
    doCmd(3'd5, 4'd0);
    doWrite();
    doCr();
    chkPos("R8", 5, 32, 3, 0);
    chk("R8", "clrReq paused", int'(clrReq), 0);
    doCmd(3'd1, 4'd0);
    chkPos("R8", 5, 32, 3, 0);
    chk("R8", "clrAll resume", int'(clrAll), 0);
    doCr();
    chkPos("R8", 3, 1, 4, 13);
  endtask

  task automatic testClamp();
    cfgTextRows = 4'd0; cfgTextBase = 4'd0;
    doCmd(3'd0, 4'd0);
    chkPos("R7", 15, 1, 15, 0);
    doCr();
    chkPos("R7", 15, 1, 15, 13);
    chk("R7", "clrRow", int'(clrRow), 15);
    cfgTextRows = 4'd9; cfgTextBase = 4'd4;
    doCmd(3'd0, 4'd0);
    chkPos("R7", 1, 1, 1, 0);
    repeat (3) doCr();
    chkPos("R7", 4, 1, 1, 0);
    doCr();
    chkPos("R4", 1, 1, 2, 13);
  endtask

  task automatic testRollUp();
    doCmd(3'd6, 4'd10);
    chkPos("R10", 1, 1, 2, 13);
    doCmd(3'd3, 4'd0);
    chkPos("R9", 10, 1, 8, 0);
    repeat (2) doWrite();
    chk("R9", "wrCol", int'(wrCol), 3);
    doCr();
    chkPos("R9", 8, 1, 9, 13);
    chk("R9", "clrRow", int'(clrRow), 8);
    doCmd(3'd6, 4'd2);
    chkPos("R10", 3, 1, 1, 0);
    doCmd(3'd6, 4'd14);
    chkPos("R10", 14, 1, 12, 0);
    doCmd(3'd4, 4'd0);
    chkPos("R9", 14, 1, 11, 0);
    doCmd(3'd2, 4'd0);
    chkPos("R9", 14, 1, 13, 0);
  endtask

  task automatic testReserved();
    doWrite();
    doCmd(3'd7, 4'd3);
    chkPos("R11", 14, 2, 13, 0);
    doCr();
    chkPos("R11", 13, 1, 14, 13);
    cfgTextRows = 4'd15; cfgTextBase = 4'd15;
    doCmd(3'd1, 4'd0);
    chkPos("R8", 1, 1, 1, 0);
    chk("R8", "clrAll resume", int'(clrAll), 0);
  endtask

  initial begin
    #2_000_000;
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testTextFillScroll();
    testColumnLimit();
    testPauseResume();
    testClamp();
    testRollUp();
    testReserved();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule